// File: doc/BRIEF.md
# Peripheral Interrupt Controller Register Bank

This block stores the control state for 60 peripheral interrupt lines and serves it through a plain 32-bit word-addressed register port. Every access carries a privilege flag. Each line has an enable bit, a pending bit, an active bit and a 5-bit priority. Enable and pending bits each have one write-one-to-set window and one write-one-to-clear window, and both windows read back the same live state. The active bits can only be read. Priorities are packed four per word. A software trigger register pends a line by its number.

Every cycle the block picks the most urgent line that is both pending and enabled. It offers that line to the core as a request and a line number. When the core accepts, the line moves from pending to active. A later return pulse ends the service. Only one line can be active at a time, and no new request is offered until the active line has been returned.

The register map uses word addresses. Enable-set is at words 0x00 and 0x01, enable-clear at 0x02 and 0x03, pending-set at 0x04 and 0x05, pending-clear at 0x06 and 0x07, and active at 0x08 and 0x09. The priority words are at 0x10 to 0x1E, the trigger register at 0x20 and the configuration register at 0x21. Any other address reads 0.

Top module: `irqc_bank`

## Requirements
- R1: After reset, all enable, pending, active, priority and configuration state is 0, irq_req is low and bus_rdata is 0.
- R2: Line n maps to bit n%32 of word n/32 (word 0 at the lower address). A 1 written to an enable-set word enables that line, and a 1 written to an enable-clear word disables it. Written 0 bits have no effect. Both windows read back the enable state.
- R3: The pending-set words (0x04/0x05) and pending-clear words (0x06/0x07) act on the pending bits in the same way, and both read back the pending state.
- R4: A high level on irq_lines[n] at a clock edge sets pending bit n, and the bit stays set after the input falls. When a hardware set and a clear reach the same line in the same cycle, the set wins.
- R5: The active words (0x08/0x09) ignore writes.
- R6: Priority word r (address 0x10+r) holds line 4r+k in bits [8k+7:8k+3]. Bits [8k+2:8k] read as 0.
- R7: When no line is active, irq_req is high if any line is pending and enabled, and irq_id gives the eligible line with the smallest priority value. Among lines with equal priority, the lowest line number wins.
- R8: At a clock edge where irq_take and irq_req are both high, the pending bit of irq_id clears and its active bit sets. irq_req then stays low while any line is active.
- R9: An irq_done pulse clears the active bit.
- R10: A privileged write of value v to the trigger register (0x20) sets pending bit v when v < 60. Values of 60 or more are ignored.
- R11: Configuration bit 0 (0x21) can be written only by privileged accesses. An unprivileged write to the trigger register is ignored unless that bit is 1.
- R12: A read access puts its data on bus_rdata one cycle later, and the value holds until the next read. Unmapped and write-only addresses (including 0x20) read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Access is privileged |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| irq_lines | input | 60 | Level-sampled hardware pend requests |
| irq_req | output | 1 | A line is offered to the core |
| irq_id | output | 6 | Number of the offered line |
| irq_take | input | 1 | Core accepts the offered line |
| irq_done | input | 1 | Core returns the active line |

## Verification
A write, a hardware level, a take or a return changes the state at the edge that samples it. irq_req and irq_id are combinational from that state, so they are correct right after the edge. Read data is registered and appears one edge after the read is sampled. The bench drives every input at a falling edge and checks request outputs at the next falling edge. A monitor compares read data at the falling edge after each read against a queue of expected words that the read task pushed, so every comparison is made exactly when its result is due.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] A_EN_SET = 6'h00;
    localparam logic [ADDR_W-1:0] A_EN_CLR = 6'h02;
    localparam logic [ADDR_W-1:0] A_PD_SET = 6'h04;
    localparam logic [ADDR_W-1:0] A_PD_CLR = 6'h06;
    localparam logic [ADDR_W-1:0] A_ACT    = 6'h08;
    localparam logic [ADDR_W-1:0] A_PRIO   = 6'h10;
    localparam logic [ADDR_W-1:0] A_TRIG   = 6'h20;
    localparam logic [ADDR_W-1:0] A_CFG    = 6'h21;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic              priv;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int NUM    = 60,
    parameter int PRIO_W = 5
) (
    input  bus_req_t                      req,
    input  logic                          cfg_unpriv,
    output logic [NUM-1:0]                en_set,
    output logic [NUM-1:0]                en_clr,
    output logic [NUM-1:0]                pd_set,
    output logic [NUM-1:0]                pd_clr,
    output logic [NUM-1:0]                prio_we,
    output logic [NUM-1:0][PRIO_W-1:0]    prio_wval,
    output logic                          cfg_we,
    output logic                          cfg_wval
);
    localparam int LANE_LO = 8 - PRIO_W;

    logic wr;
    logic trig_ok;

    always_comb begin
        wr      = req.valid && req.write;
        trig_ok = wr && (req.addr == A_TRIG) && (req.priv || cfg_unpriv)
                  && (req.wdata < DATA_W'(NUM));
        cfg_we  = wr && req.priv && (req.addr == A_CFG);
        cfg_wval = req.wdata[0];
        for (int i = 0; i < NUM; i++) begin
            en_set[i] = wr && (req.addr == A_EN_SET + ADDR_W'(i / 32)) && req.wdata[i % 32];
            en_clr[i] = wr && (req.addr == A_EN_CLR + ADDR_W'(i / 32)) && req.wdata[i % 32];
            pd_set[i] = (wr && (req.addr == A_PD_SET + ADDR_W'(i / 32)) && req.wdata[i % 32])
                        || (trig_ok && (req.wdata[ADDR_W-1:0] == ADDR_W'(i)));
            pd_clr[i] = wr && (req.addr == A_PD_CLR + ADDR_W'(i / 32)) && req.wdata[i % 32];
            prio_we[i]   = wr && (req.addr == A_PRIO + ADDR_W'(i / 4));
            prio_wval[i] = req.wdata[8 * (i % 4) + LANE_LO +: PRIO_W];
        end
    end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int NUM    = 60,
    parameter int PRIO_W = 5,
    parameter int ID_W   = $clog2(NUM)
) (
    input  logic [NUM-1:0]             elig,
    input  logic [NUM-1:0][PRIO_W-1:0] prio,
    output logic                       found,
    output logic [ID_W-1:0]            win_id
);
    logic [PRIO_W-1:0] best;

    always_comb begin
        found  = 1'b0;
        win_id = '0;
        best   = '1;
        for (int i = 0; i < NUM; i++) begin
            if (elig[i] && (!found || (prio[i] < best))) begin
                found  = 1'b1;
                best   = prio[i];
                win_id = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/irqc_state.sv
module irqc_state #(
    parameter int NUM    = 60,
    parameter int PRIO_W = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM-1:0]             en_set,
    input  logic [NUM-1:0]             en_clr,
    input  logic [NUM-1:0]             pd_set,
    input  logic [NUM-1:0]             pd_clr,
    input  logic [NUM-1:0]             prio_we,
    input  logic [NUM-1:0][PRIO_W-1:0] prio_wval,
    input  logic                       cfg_we,
    input  logic                       cfg_wval,
    input  logic [NUM-1:0]             hw_lines,
    input  logic [NUM-1:0]             take_mask,
    input  logic                       done,
    output logic [NUM-1:0]             en_q,
    output logic [NUM-1:0]             pend_q,
    output logic [NUM-1:0]             act_q,
    output logic [NUM-1:0][PRIO_W-1:0] prio_q,
    output logic                       cfg_q
);
    typedef struct packed {
        logic [NUM-1:0]             en;
        logic [NUM-1:0]             pend;
        logic [NUM-1:0]             act;
        logic [NUM-1:0][PRIO_W-1:0] prio;
        logic                       cfg;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.en   = (st_q.en & ~en_clr) | en_set;
        st_d.pend = (st_q.pend & ~pd_clr & ~take_mask) | pd_set | hw_lines;
        st_d.act  = (done ? '0 : st_q.act) | take_mask;
        for (int i = 0; i < NUM; i++) begin
            if (prio_we[i]) st_d.prio[i] = prio_wval[i];
        end
        if (cfg_we) st_d.cfg = cfg_wval;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q   = st_q.en;
    assign pend_q = st_q.pend;
    assign act_q  = st_q.act;
    assign prio_q = st_q.prio;
    assign cfg_q  = st_q.cfg;

    AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.act)); // R8
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && take_mask == '0) |=> (st_q.act == '0)); // R9
    AST_HW_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_lines != '0) |=> ((st_q.pend & $past(hw_lines)) == $past(hw_lines))); // R4
    AST_CFG_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(st_q.cfg)); // R11
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
#(
    parameter int NUM    = 60,
    parameter int PRIO_W = 5,
    parameter int ID_W   = $clog2(NUM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_priv,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM-1:0]    irq_lines,
    output logic              irq_req,
    output logic [ID_W-1:0]   irq_id,
    input  logic              irq_take,
    input  logic              irq_done
);
    localparam int NUM_WORDS = (NUM + 31) / 32;
    localparam int PAD_W     = NUM_WORDS * 32;
    localparam int PRIO_REGS = (NUM + 3) / 4;
    localparam int LANE_LO   = 8 - PRIO_W;

    bus_req_t                   req;
    logic [NUM-1:0]             en_set, en_clr, pd_set, pd_clr, prio_we;
    logic [NUM-1:0][PRIO_W-1:0] prio_wval;
    logic                       cfg_we, cfg_wval;
    logic [NUM-1:0]             en_q, pend_q, act_q;
    logic [NUM-1:0][PRIO_W-1:0] prio_q;
    logic                       cfg_q;
    logic [NUM-1:0]             take_mask;
    logic                       found;
    logic [ID_W-1:0]            win_id;
    logic                       take_fire;

    logic [PAD_W-1:0]                      en_pad, pend_pad, act_pad;
    logic [PRIO_REGS*4-1:0][PRIO_W-1:0]    prio_pad;
    logic [DATA_W-1:0]                     rdata_d, rdata_q;

    assign req = '{valid: bus_valid, write: bus_write, priv: bus_priv,
                   addr: bus_addr, wdata: bus_wdata};

    irqc_decode #(.NUM(NUM), .PRIO_W(PRIO_W)) u_decode (
        .req(req), .cfg_unpriv(cfg_q),
        .en_set(en_set), .en_clr(en_clr), .pd_set(pd_set), .pd_clr(pd_clr),
        .prio_we(prio_we), .prio_wval(prio_wval),
        .cfg_we(cfg_we), .cfg_wval(cfg_wval)
    );

    irqc_arbiter #(.NUM(NUM), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
        .elig(en_q & pend_q), .prio(prio_q), .found(found), .win_id(win_id)
    );

    assign irq_req   = found && (act_q == '0);
    assign irq_id    = win_id;
    assign take_fire = irq_take && irq_req;

    always_comb begin
        take_mask = '0;
        for (int i = 0; i < NUM; i++) begin
            if (take_fire && (win_id == ID_W'(i))) take_mask[i] = 1'b1;
        end
    end

    irqc_state #(.NUM(NUM), .PRIO_W(PRIO_W)) u_state (
        .clk(clk), .rst_n(rst_n),
        .en_set(en_set), .en_clr(en_clr), .pd_set(pd_set), .pd_clr(pd_clr),
        .prio_we(prio_we), .prio_wval(prio_wval),
        .cfg_we(cfg_we), .cfg_wval(cfg_wval),
        .hw_lines(irq_lines), .take_mask(take_mask), .done(irq_done),
        .en_q(en_q), .pend_q(pend_q), .act_q(act_q), .prio_q(prio_q), .cfg_q(cfg_q)
    );

    always_comb begin
        en_pad   = PAD_W'(en_q);
        pend_pad = PAD_W'(pend_q);
        act_pad  = PAD_W'(act_q);
        prio_pad = '0;
        for (int i = 0; i < NUM; i++) prio_pad[i] = prio_q[i];
    end

    always_comb begin
        rdata_d = rdata_q;
        if (bus_valid && !bus_write) begin
            rdata_d = '0;
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (bus_addr == A_EN_SET + ADDR_W'(w) || bus_addr == A_EN_CLR + ADDR_W'(w))
                    rdata_d = en_pad[w*32 +: 32];
                if (bus_addr == A_PD_SET + ADDR_W'(w) || bus_addr == A_PD_CLR + ADDR_W'(w))
                    rdata_d = pend_pad[w*32 +: 32];
                if (bus_addr == A_ACT + ADDR_W'(w))
                    rdata_d = act_pad[w*32 +: 32];
            end
            for (int r = 0; r < PRIO_REGS; r++) begin
                if (bus_addr == A_PRIO + ADDR_W'(r)) begin
                    for (int k = 0; k < 4; k++)
                        rdata_d[8*k + LANE_LO +: PRIO_W] = prio_pad[4*r + k];
                end
            end
            if (bus_addr == A_CFG) rdata_d[0] = cfg_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata = rdata_q;

    AST_OFFER_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (en_q[irq_id] && pend_q[irq_id])); // R7
    AST_TAKE_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && irq_req && !irq_done) |=> act_q[$past(irq_id)]); // R8
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata)); // R12
endmodule

// File: tb/tb_irqc_bank.sv
module tb_irqc_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0, bus_priv = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [59:0] irq_lines = '0;
    logic        irq_req;
    logic [5:0]  irq_id;
    logic        irq_take = 1'b0, irq_done = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #2 clk = ~clk;

    irqc_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_priv(bus_priv), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_lines(irq_lines), .irq_req(irq_req),
        .irq_id(irq_id), .irq_take(irq_take), .irq_done(irq_done)
    );

    // monitor: pops one expected word per sampled read
    always @(posedge clk) rd_seen <= bus_valid && !bus_write;
    always @(negedge clk) begin
        if (rd_seen) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: actual %h expected none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic p = 1'b1);
        bus_valid = 1'b1; bus_write = 1'b1; bus_priv = p; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_priv = 1'b1;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] e, input string t);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", t, act, e);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk({31'd0, irq_req}, 32'd0, "R1 irq_req");
        chk(bus_rdata, 32'd0, "R1 rdata");
        rd(6'h00, 32'h0, "R1 enable");
        rd(6'h04, 32'h0, "R1 pending");
        rd(6'h08, 32'h0, "R1 active");
        rd(6'h10, 32'h0, "R1 priority");
        rd(6'h21, 32'h0, "R1 config");
        // R2 enable set/clear
        wr(6'h00, 32'h5);
        rd(6'h00, 32'h5, "R2 set view");
        rd(6'h02, 32'h5, "R2 clear view");
        wr(6'h01, 32'h0800_0000);
        rd(6'h01, 32'h0800_0000, "R2 word1 line59");
        wr(6'h02, 32'h4);
        rd(6'h00, 32'h1, "R2 clear line2");
        wr(6'h02, 32'h0);
        rd(6'h00, 32'h1, "R2 zero no effect");
        // R6 priority packing
        wr(6'h10, 32'hFF10_0807);
        rd(6'h10, 32'hF810_0800, "R6 lanes");
        // R3 pending, R7 selection
        wr(6'h05, 32'h0800_0000);
        rd(6'h05, 32'h0800_0000, "R3 set view");
        rd(6'h07, 32'h0800_0000, "R3 clear view");
        chk({26'd0, irq_req, irq_id}, {26'd0, 1'b1, 6'd59}, "R7 single line");
        wr(6'h04, 32'h1);
        chk({26'd0, irq_req, irq_id}, {26'd0, 1'b1, 6'd0}, "R7 tie lowest number");
        wr(6'h1E, 32'h0800_0000);
        chk({26'd0, irq_req, irq_id}, {26'd0, 1'b1, 6'd0}, "R7 urgent line0");
        wr(6'h06, 32'h1);
        rd(6'h04, 32'h0, "R3 clear line0");
        chk({26'd0, irq_req, irq_id}, {26'd0, 1'b1, 6'd59}, "R7 after clear");
        wr(6'h10, 32'h0000_00F8);
        wr(6'h04, 32'h1);
        chk({26'd0, irq_req, irq_id}, {26'd0, 1'b1, 6'd59}, "R7 priority over number");
        // R8 take
        irq_take = 1'b1;
        @(negedge clk);
        irq_take = 1'b0;
        chk({31'd0, irq_req}, 32'd0, "R8 no request while active");
        rd(6'h09, 32'h0800_0000, "R8 active set");
        rd(6'h05, 32'h0, "R8 pending cleared");
        // R5 active read-only
        wr(6'h09, 32'h0);
        wr(6'h08, 32'hFFFF_FFFF);
        rd(6'h09, 32'h0800_0000, "R5 word1 kept");
        rd(6'h08, 32'h0, "R5 word0 kept");
        // R9 return
        irq_done = 1'b1;
        @(negedge clk);
        irq_done = 1'b0;
        rd(6'h09, 32'h0, "R9 active cleared");
        chk({26'd0, irq_req, irq_id}, {26'd0, 1'b1, 6'd0}, "R9 next request");
        // R4 hardware set beats clear
        irq_lines[0] = 1'b1;
        wr(6'h06, 32'h1);
        irq_lines[0] = 1'b0;
        rd(6'h04, 32'h1, "R4 set wins");
        wr(6'h06, 32'h1);
        irq_lines[5] = 1'b1;
        @(negedge clk);
        irq_lines[5] = 1'b0;
        rd(6'h04, 32'h20, "R4 sticky level");
        // R10 trigger
        wr(6'h20, 32'd33);
        rd(6'h05, 32'h2, "R10 trigger line33");
        wr(6'h20, 32'd62);
        rd(6'h05, 32'h2, "R10 out of range word1");
        rd(6'h04, 32'h20, "R10 out of range word0");
        // R11 privilege gating
        wr(6'h20, 32'd34, 1'b0);
        rd(6'h05, 32'h2, "R11 unpriv ignored");
        wr(6'h21, 32'h1, 1'b0);
        rd(6'h21, 32'h0, "R11 unpriv config ignored");
        wr(6'h21, 32'h1, 1'b1);
        rd(6'h21, 32'h1, "R11 config set");
        chk(bus_rdata, 32'h1, "R12 hold");
        wr(6'h20, 32'd34, 1'b0);
        rd(6'h05, 32'h6, "R11 unpriv allowed");
        // R12 unmapped and write-only reads
        rd(6'h3F, 32'h0, "R12 unmapped");
        rd(6'h20, 32'h0, "R12 trigger reads zero");
        @(negedge clk);
        chk(bus_rdata, 32'h0, "R12 hold zero");
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard leftover: actual %0d expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule